// File: doc/BRIEF.md
# Partial-Word Store Byte-Enable Unit

This unit converts a "store bytes" request into exactly one masked write beat toward memory. The memory is big-endian: byte lane 0 of a beat is the most significant byte of the word. A request carries a byte address, a 64-bit register value, a mode bit and a size bit. The mode bit selects one of two behaviours. In begin mode, the bytes from the address offset to the last lane of the word are stored. In end mode, the lanes below the offset are stored. The size bit selects a 4-byte word or an 8-byte doubleword, and the offset is the address modulo that size.

The unit does not shift the register value. In begin mode the selected lanes already line up with the register's least significant bytes, and in end mode they line up with its most significant bytes, so only the byte enables change with offset and mode. Every request becomes a single beat, so stores of 3, 5, 6 or 7 bytes reach memory in one piece and appear atomic. An end-mode request at offset 0 stores nothing. It still produces a beat with an all-zero enable and a probe flag, which asks the memory side to check write permission and mark the line dirty.

A request is taken through a valid/ready handshake into a single output register. The output register holds its beat until the downstream side accepts it.

Top module: `pstore_lane_unit`

## Requirements
- R1: While reset is held and right after it is released, `wr_valid` is low and `req_ready` is high.
- R2: `wr_addr` is `req_addr` rounded down to the access size: a multiple of 4 for words and of 8 for doublewords.
- R3: In begin mode (`req_end`=0) with offset o, bit k of `wr_be` (lane k, lane 0 the most significant byte) is set exactly for o <= k < size. Offset 0 enables the whole word.
- R4: In end mode (`req_end`=1) with offset o, bit k of `wr_be` is set exactly for k < o.
- R5: `wr_probe` is high exactly when the beat is an end-mode request at offset 0. That beat has `wr_be` all zero.
- R6: For word accesses (`req_wide`=0), the offset is `req_addr` modulo 4 and `wr_be[7:4]` is zero.
- R7: `wr_data` equals the accepted `req_data` unchanged.
- R8: `req_ready` is high exactly when the output register is empty or `wr_ready` is high. While `wr_valid` is high and `wr_ready` is low, every `wr_*` output holds its value.
- R9: A request accepted on a clock edge is presented with `wr_valid` high after that edge. A beat leaves only on an edge where `wr_valid` and `wr_ready` are both high.
- R10: Each beat's enable is one contiguous run of lanes, so a store of any length from 1 to 8 bytes is carried by a single beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this edge when valid |
| req_addr | input | ADDR_W | Byte address of the store |
| req_data | input | 64 | Register value to store |
| req_end | input | 1 | 0 = begin mode, 1 = end mode |
| req_wide | input | 1 | 0 = 4-byte word, 1 = 8-byte doubleword |
| wr_valid | output | 1 | Write beat present |
| wr_ready | input | 1 | Downstream accepts the beat |
| wr_addr | output | ADDR_W | Size-aligned beat address |
| wr_be | output | 8 | Byte enables, bit k = big-endian lane k |
| wr_data | output | 64 | Unshifted store data |
| wr_probe | output | 1 | Zero-length write-permission probe |

## Verification
The stimulus first sweeps every offset from 0 to 7 for each combination of mode and size while the output is never stalled. This sweep separates the begin-mode and end-mode masks, shows that word accesses ignore address bit 2, and isolates the probe case at offset 0 in end mode. A stall sequence holds `wr_ready` low while new requests keep arriving. It shows that the stored beat stays frozen and that no request is taken until the beat drains. A long stretch with random requests and random backpressure then exercises back-to-back acceptance, in which a beat leaves on the same edge the next one is loaded. Across all of these, the bench compares address rounding, enables, data and probe against a behavioural model.

// File: rtl/pstore_pkg.sv
package pstore_pkg;

  localparam int WIDE_LANES   = 8;
  localparam int NARROW_LANES = 4;
  localparam int OFS_W        = $clog2(WIDE_LANES);
  localparam int BEAT_DW      = 8 * WIDE_LANES;

  typedef struct packed {
    logic [WIDE_LANES-1:0] be;
    logic [BEAT_DW-1:0]    data;
    logic                  probe;
    logic                  wide;
    logic                  end_mode;
  } beat_t;

  // Offset of the byte address inside the selected access size.
  function automatic logic [OFS_W-1:0] lane_offset(input logic [OFS_W-1:0] addr_lo,
                                                   input logic wide);
    return wide ? addr_lo : {1'b0, addr_lo[OFS_W-2:0]};
  endfunction

  // Whether lane number `lane` is written for the given offset and mode.
  function automatic logic lane_hit(input logic [OFS_W-1:0] lane,
                                    input logic [OFS_W-1:0] offset,
                                    input logic end_mode);
    return end_mode ? (lane < offset) : (lane >= offset);
  endfunction

endpackage

// File: rtl/pstore_mask_gen.sv
module pstore_mask_gen
  import pstore_pkg::*;
(
  input  logic [OFS_W-1:0]      addr_lo,
  input  logic                  wide,
  input  logic                  end_mode,
  output logic [WIDE_LANES-1:0] lane_be,
  output logic                  probe_only
);

  logic [OFS_W-1:0] offset;
  assign offset = lane_offset(addr_lo, wide);

  for (genvar k = 0; k < WIDE_LANES; k++) begin : g_lane
    localparam logic [OFS_W-1:0] LANE = OFS_W'(k);
    localparam bit IN_NARROW = (k < NARROW_LANES);
    logic in_word;
    assign in_word    = wide || IN_NARROW;
    assign lane_be[k] = in_word && lane_hit(LANE, offset, end_mode);
  end

  assign probe_only = end_mode && (offset == '0);

endmodule

// File: rtl/pstore_align.sv
module pstore_align
  import pstore_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:OFS_W-1] addr_hi,
  input  logic                    wide,
  output logic [ADDR_W-1:0]       aligned
);

  assign aligned = {addr_hi[ADDR_W-1:OFS_W],
                    wide ? 1'b0 : addr_hi[OFS_W-1],
                    {(OFS_W-1){1'b0}}};

endmodule

// File: rtl/pstore_out_stage.sv
module pstore_out_stage
  import pstore_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] in_addr,
  input  beat_t             in_beat,
  output logic              can_accept,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output beat_t             out_beat
);

  assign can_accept = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_beat  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_addr  <= in_addr;
      out_beat  <= in_beat;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/pstore_lane_unit.sv
module pstore_lane_unit
  import pstore_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [BEAT_DW-1:0]    req_data,
  input  logic                  req_end,
  input  logic                  req_wide,
  output logic                  wr_valid,
  input  logic                  wr_ready,
  output logic [ADDR_W-1:0]     wr_addr,
  output logic [WIDE_LANES-1:0] wr_be,
  output logic [BEAT_DW-1:0]    wr_data,
  output logic                  wr_probe
);

  logic [WIDE_LANES-1:0] next_be;
  logic                  next_probe;
  logic [ADDR_W-1:0]     next_addr;
  logic                  req_fire;
  beat_t                 next_beat;
  beat_t                 stage_beat;
  logic                  stage_wide;
  logic                  stage_end;

  pstore_mask_gen u_mask (
    .addr_lo    (req_addr[OFS_W-1:0]),
    .wide       (req_wide),
    .end_mode   (req_end),
    .lane_be    (next_be),
    .probe_only (next_probe)
  );

  pstore_align #(.ADDR_W(ADDR_W)) u_align (
    .addr_hi (req_addr[ADDR_W-1:OFS_W-1]),
    .wide    (req_wide),
    .aligned (next_addr)
  );

  assign next_beat = '{be: next_be, data: req_data, probe: next_probe,
                       wide: req_wide, end_mode: req_end};
  assign req_fire  = req_valid && req_ready;

  pstore_out_stage #(.ADDR_W(ADDR_W)) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (req_fire),
    .in_addr    (next_addr),
    .in_beat    (next_beat),
    .can_accept (req_ready),
    .out_valid  (wr_valid),
    .out_ready  (wr_ready),
    .out_addr   (wr_addr),
    .out_beat   (stage_beat)
  );

  assign wr_be      = stage_beat.be;
  assign wr_data    = stage_beat.data;
  assign wr_probe   = stage_beat.probe;
  assign stage_wide = stage_beat.wide;
  assign stage_end  = stage_beat.end_mode;

endmodule

// File: rtl/pstore_lane_unit_chk.sv
module pstore_lane_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [63:0]       req_data,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_be,
  input logic [63:0]       wr_data,
  input logic              wr_probe,
  input logic              stage_wide,
  input logic              stage_end
);

  logic [8:0] be_ext;
  logic [8:0] be_fill;
  logic       be_contig;
  assign be_ext    = {1'b0, wr_be};
  assign be_fill   = (be_ext | (be_ext - 9'd1)) + 9'd1;
  assign be_contig = ((be_fill & be_ext) == 9'd0);

  assert_accept_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> wr_valid);

  assert_data_unshifted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> wr_data == $past(req_data));

  assert_hold_under_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_be)
                              && $stable(wr_data) && $stable(wr_probe));

  assert_no_take_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |-> !req_ready);

  assert_probe_means_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_probe == (wr_be == 8'h00)));

  assert_addr_rounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[1:0] == 2'b00) && (!stage_wide || !wr_addr[2]));

  assert_word_upper_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !stage_wide |-> wr_be[7:4] == 4'h0);

  assert_begin_reaches_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !stage_end |-> (stage_wide ? wr_be[7] : wr_be[3]));

  assert_end_starts_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && stage_end && !wr_probe |-> wr_be[0]);

  assert_single_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> be_contig);

endmodule

bind pstore_lane_unit pstore_lane_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_data   (req_data),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_addr    (wr_addr),
  .wr_be      (wr_be),
  .wr_data    (wr_data),
  .wr_probe   (wr_probe),
  .stage_wide (stage_wide),
  .stage_end  (stage_end)
);

// File: tb/pstore_lane_unit_bench.sv
module pstore_lane_unit_bench;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [63:0]   req_data = '0;
  logic          req_end = 1'b0;
  logic          req_wide = 1'b0;
  logic          wr_valid;
  logic          wr_ready = 1'b0;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_be;
  logic [63:0]   wr_data;
  logic          wr_probe;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;
  bit done    = 0;

  typedef struct {
    logic [AW-1:0] addr;
    logic [7:0]    be;
    logic [63:0]   data;
    logic          probe;
    logic          em;
    logic          dw;
  } exp_beat_t;

  exp_beat_t pend[$];

  always #2 clk = ~clk;

  pstore_lane_unit #(.ADDR_W(AW)) u_pstore_lane_unit (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_data(req_data), .req_end(req_end), .req_wide(req_wide),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_be(wr_be), .wr_data(wr_data), .wr_probe(wr_probe)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_beat_t model(input logic [AW-1:0] a, input logic [63:0] d,
                                      input logic em, input logic dw);
    exp_beat_t b;
    int size = dw ? 8 : 4;
    int ofs  = int'(a % size);
    b.addr  = a - AW'(ofs);
    b.be    = 8'h00;
    for (int k = 0; k < size; k++)
      if (em ? (k < ofs) : (k >= ofs)) b.be[k] = 1'b1;
    b.data  = d;
    b.probe = em && (ofs == 0);
    b.em    = em;
    b.dw    = dw;
    return b;
  endfunction

  task automatic tick(input logic v, input logic [AW-1:0] a, input logic [63:0] d,
                      input logic em, input logic dw, input logic rdy);
    bit have;
    exp_beat_t h;
    req_valid = v; req_addr = a; req_data = d; req_end = em; req_wide = dw; wr_ready = rdy;
    #1;
    have = (pend.size() != 0);
    check("R9 wr_valid", 64'(wr_valid), 64'(have));
    check("R8 req_ready", 64'(req_ready), 64'(!have || rdy));
    if (have) begin
      h = pend[0];
      check("R2 wr_addr", 64'(wr_addr), 64'(h.addr));
      if (h.em) check(h.dw ? "R4 R10 wr_be" : "R4 R6 wr_be", 64'(wr_be), 64'(h.be));
      else      check(h.dw ? "R3 R10 wr_be" : "R3 R6 wr_be", 64'(wr_be), 64'(h.be));
      check("R7 wr_data", wr_data, h.data);
      check("R5 wr_probe", 64'(wr_probe), 64'(h.probe));
    end
    if (have && rdy) void'(pend.pop_front());
    if (v && (!have || rdy)) pend.push_back(model(a, d, em, dw));
    @(negedge clk);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        misses++;
        $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
        done = 1;
        report();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 wr_valid in reset", 64'(wr_valid), 64'd0);
    check("R1 req_ready in reset", 64'(req_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 wr_valid after reset", 64'(wr_valid), 64'd0);
    check("R1 req_ready after reset", 64'(req_ready), 64'd1);

    // Full sweep of offsets, modes and sizes with no backpressure (R3 R4 R5 R6 R10).
    for (int dw = 0; dw < 2; dw++)
      for (int em = 0; em < 2; em++)
        for (int ofs = 0; ofs < 8; ofs++)
          tick(1'b1, 32'h4000_1230 + AW'(ofs) + AW'(dw * 64),
               64'h0123_4567_89AB_CDEF ^ 64'(ofs * 16'h1111),
               em[0], dw[0], 1'b1);
    tick(1'b0, '0, '0, 1'b0, 1'b0, 1'b1);

    // Stall: beat must freeze and new requests wait (R8).
    tick(1'b1, 32'h0000_0105, 64'hFEDC_BA98_7654_3210, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++)
      tick(1'b1, 32'h0000_0200 + AW'(i), 64'(i) * 64'h0101_0101_0101_0101,
           1'b0, 1'b0, 1'b0);
    tick(1'b1, 32'h0000_0203, 64'hAAAA_5555_AAAA_5555, 1'b0, 1'b0, 1'b1);
    tick(1'b0, '0, '0, 1'b0, 1'b0, 1'b1);
    tick(1'b0, '0, '0, 1'b0, 1'b0, 1'b1);

    // Random traffic with random backpressure.
    for (int i = 0; i < 2000; i++)
      tick(($urandom % 4) != 0, $urandom, {$urandom, $urandom},
           $urandom % 2 == 1, $urandom % 2 == 1, ($urandom % 3) != 0);
    for (int i = 0; i < 4; i++)
      tick(1'b0, '0, '0, 1'b0, 1'b0, 1'b1);

    done = 1;
    report();
  end

endmodule